// File: doc/BRIEF.md
# Supply Droop Reset Guard

This block is the digital side of a supply-voltage monitor. Two comparator outputs arrive asynchronously. One says the supply has dropped below the lower (falling) threshold. The other says the supply has recovered above the upper (rising) threshold. Both pass through a two-stage synchronizer before any logic looks at them. Four configuration inputs set how the block behaves:

- power the monitor off;
- keep the monitor but suppress its reset;
- keep the monitor running while the system is in stop mode;
- pick which of two threshold sets the analog reference uses.

In polled use, software reads an 8-bit status word whose top bit mirrors the low-supply comparator. In forced-reset use, a low supply starts a reset request to the system reset controller and pulls an open-drain-style reset pin low. Hysteresis holds that request until the rising-threshold comparator reports recovery. A supply that only climbs back above the lower threshold does not release it.

Top module: `vdrop_guard`

## Requirements
- R1: When the power-down input is 1, the status word reads 0x00 and no reset request is raised; a request already raised drops on the next clock.
- R2: With power-down 0 and reset-disable 1, status bit 7 follows the synchronized low-supply input and the reset request stays 0.
- R3: With power-down 0 and reset-disable 0, a synchronized low-supply input raises the reset request on the following clock, three rising edges after the raw input changes.
- R4: Once raised, the request stays 1 while the synchronized recovery input is 0, even after the low-supply input returns to 0.
- R5: A synchronized recovery input of 1 while the request is held clears the request on the next clock.
- R6: The status word carries the flag in bit 7 (1 = supply at or below the trip level, 0 = above) and reads 0 in bits 6 to 0; after reset it is 0x00.
- R7: The reset pin output is 0 exactly when the reset request is 1, and 1 otherwise.
- R8: While stop mode is 1 and the stop-run bit is 0, the block behaves as powered down (R1). With the stop-run bit at 1, stop mode has no effect.
- R9: The range-select input is passed unchanged to the reference-select output.
- R10: Status bit 7 reflects a raw low-supply change after exactly two rising edges.
- R11: Setting reset-disable to 1 while the request is held clears the request on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_low_i | input | 1 | Asynchronous comparator: supply below falling threshold |
| cmp_ok_i | input | 1 | Asynchronous comparator: supply above rising threshold |
| cfg_off_i | input | 1 | Power the monitor down |
| cfg_norst_i | input | 1 | Suppress reset generation (polled mode) |
| cfg_stop_run_i | input | 1 | Keep monitoring during stop mode |
| cfg_range_i | input | 1 | Threshold set selection |
| stop_mode_i | input | 1 | System is in stop mode |
| status_o | output | 8 | Read-only status word |
| rst_req_o | output | 1 | Reset request to the system reset controller |
| rst_pin_n_o | output | 1 | External reset pin drive, low while requesting |
| ref_sel_o | output | 1 | Reference threshold set selection to the analog side |

## Verification
The assertions assume the two comparators never both report 1 in the same cycle after synchronization, because a supply cannot be below the lower threshold and above the upper one at once. The random stimulus therefore draws one of three comparator states each time it changes them: low, recovered or in between, and never both. Configuration inputs change only now and then, so trip, hold and release episodes run to completion between changes. Directed sequences cover the hysteresis window and a disable arriving mid-trip.

// File: rtl/vdg_pkg.sv
package vdg_pkg;
  localparam int STAT_W   = 8;
  localparam int FLAG_BIT = STAT_W - 1;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_TRIPPED = 1'b1
  } hold_state_t;

  // Monitor is live unless powered off or stopped without the stop-run bit.
  function automatic logic monitor_live(input logic off, input logic stop,
                                        input logic stop_run);
    return !off && !(stop && !stop_run);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic flag);
    logic [STAT_W-1:0] w;
    w = '0;
    w[FLAG_BIT] = flag;
    return w;
  endfunction
endpackage

// File: rtl/vdg_sync.sv
module vdg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/vdg_hold_fsm.sv
module vdg_hold_fsm
  import vdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,
  input  logic norst_i,
  input  logic low_i,
  input  logic ok_i,
  output logic req_o,
  output logic trip_evt_o,
  output logic release_evt_o
);
  hold_state_t st, st_nx;
  logic armed;

  assign armed = live_i && !norst_i;

  always_comb begin
    st_nx         = st;
    trip_evt_o    = 1'b0;
    release_evt_o = 1'b0;
    unique case (st)
      ST_IDLE: if (armed && low_i) begin
        st_nx      = ST_TRIPPED;
        trip_evt_o = 1'b1;
      end
      ST_TRIPPED: if (!armed || ok_i) begin
        st_nx         = ST_IDLE;
        release_evt_o = 1'b1;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign req_o = (st == ST_TRIPPED);
endmodule

// File: rtl/vdrop_guard.sv
module vdrop_guard
  import vdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_low_i,
  input  logic              cmp_ok_i,
  input  logic              cfg_off_i,
  input  logic              cfg_norst_i,
  input  logic              cfg_stop_run_i,
  input  logic              cfg_range_i,
  input  logic              stop_mode_i,
  output logic [STAT_W-1:0] status_o,
  output logic              rst_req_o,
  output logic              rst_pin_n_o,
  output logic              ref_sel_o
);
  logic [1:0] raw_cmp, sync_cmp;
  logic low_s, ok_s, live;
  logic trip_evt, release_evt;

  assign raw_cmp = {cmp_ok_i, cmp_low_i};

  vdg_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_cmp),
    .q_o   (sync_cmp)
  );

  assign low_s = sync_cmp[0];
  assign ok_s  = sync_cmp[1];
  assign live  = monitor_live(cfg_off_i, stop_mode_i, cfg_stop_run_i);

  vdg_hold_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .live_i        (live),
    .norst_i       (cfg_norst_i),
    .low_i         (low_s),
    .ok_i          (ok_s),
    .req_o         (rst_req_o),
    .trip_evt_o    (trip_evt),
    .release_evt_o (release_evt)
  );

  assign status_o    = pack_status(live && low_s);
  assign rst_pin_n_o = !rst_req_o;
  assign ref_sel_o   = cfg_range_i;
endmodule

// File: rtl/vdg_checker.sv
module vdg_checker
  import vdg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              low_s,
  input logic              ok_s,
  input logic              live,
  input logic              cfg_norst_i,
  input logic              cfg_range_i,
  input logic [STAT_W-1:0] status_o,
  input logic              rst_req_o,
  input logic              rst_pin_n_o,
  input logic              ref_sel_o,
  input logic              trip_evt,
  input logic              release_evt
);
  a_r1_dead_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !rst_req_o);
  a_r1_dead_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> status_o == '0);
  a_r2_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_norst_i |=> !rst_req_o);
  a_r3_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req_o && live && !cfg_norst_i && low_s) |=> rst_req_o);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && live && !cfg_norst_i && !ok_s) |=> rst_req_o);
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && ok_s) |=> !rst_req_o);
  a_r6_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[STAT_W-2:0] == '0);
  a_r7_pin: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin_n_o != rst_req_o);
  a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel_o == cfg_range_i);
  a_r11_evt_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(trip_evt && release_evt));
  a_r11_release_evt: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> $fell(rst_req_o));
  a_r3_comparator_sane: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_s && ok_s));
endmodule

bind vdrop_guard vdg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .low_s       (low_s),
  .ok_s        (ok_s),
  .live        (live),
  .cfg_norst_i (cfg_norst_i),
  .cfg_range_i (cfg_range_i),
  .status_o    (status_o),
  .rst_req_o   (rst_req_o),
  .rst_pin_n_o (rst_pin_n_o),
  .ref_sel_o   (ref_sel_o),
  .trip_evt    (trip_evt),
  .release_evt (release_evt)
);

// File: tb/sim_vdrop_guard.sv
`timescale 1ns/1ps
module sim_vdrop_guard;
  logic clk = 0, rst_n = 0;
  logic cmp_low = 0, cmp_ok = 0, c_off = 0, c_norst = 0, c_srun = 0;
  logic c_range = 0, stop = 0;
  logic [7:0] status;
  logic req, pin_n, ref_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vdrop_guard u0 (
    .clk(clk), .rst_n(rst_n), .cmp_low_i(cmp_low), .cmp_ok_i(cmp_ok),
    .cfg_off_i(c_off), .cfg_norst_i(c_norst), .cfg_stop_run_i(c_srun),
    .cfg_range_i(c_range), .stop_mode_i(stop), .status_o(status),
    .rst_req_o(req), .rst_pin_n_o(pin_n), .ref_sel_o(ref_sel));

  // Bench reference: own two-stage delay and held-reset flag
  logic m_l1, m_l2, m_o1, m_o2, m_held;

  function automatic bit exp_live(bit off, bit stp, bit srun);
    if (off) return 0;
    if (stp && !srun) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_l1 <= 0; m_l2 <= 0; m_o1 <= 0; m_o2 <= 0; m_held <= 0;
    end else begin
      if (!exp_live(c_off, stop, c_srun) || c_norst) m_held <= 0;
      else if (m_held && m_o2) m_held <= 0;
      else if (!m_held && m_l2) m_held <= 1;
      m_l1 <= cmp_low; m_l2 <= m_l1; m_o1 <= cmp_ok; m_o2 <= m_o1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [7:0] es;
    es = {exp_live(c_off, stop, c_srun) & m_l2, 7'b0};
    chk("R6/R2/R10 status", status, es);
    chk("R3/R4/R5 request", req, m_held);
    chk("R7 pin", pin_n, !m_held);
    chk("R9 range", ref_sel, c_range);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    step(2);
    chk("R6 reset status", status, 8'h00);
    chk("R7 reset pin", pin_n, 1'b1);
    rst_n = 1;
    step(1);
    // R10 latency: flag after two edges
    c_norst = 1; cmp_low = 1;
    step(1); chk("R10 one edge", status, 8'h00);
    step(1); chk("R10 two edges", status, 8'h80);
    chk("R2 polled no request", req, 1'b0);
    // R3 forced trip: third edge
    cmp_low = 0; step(3); c_norst = 0; step(1);
    cmp_low = 1; step(2); chk("R3 not yet", req, 1'b0);
    step(1); chk("R3 tripped", req, 1'b1); chk("R7 pin low", pin_n, 1'b0);
    // R4 hysteresis: low clears, no recovery
    cmp_low = 0; step(6); chk("R4 held", req, 1'b1);
    // R5 recovery
    cmp_ok = 1; step(2); chk("R5 sync seen", req, 1'b1);
    step(1); chk("R5 released", req, 1'b0);
    cmp_ok = 0; step(3);
    // R11 reset-disable mid-trip
    cmp_low = 1; step(3); chk("R11 tripped", req, 1'b1);
    c_norst = 1; step(1); chk("R11 dropped", req, 1'b0);
    c_norst = 0; step(1); chk("R11 retrip", req, 1'b1);
    // R8 stop without run disables, with run no effect
    stop = 1; c_srun = 0; step(1);
    chk("R8 stop drops", req, 1'b0); chk("R8 stop flag", status, 8'h00);
    c_srun = 1; step(1); chk("R8 stop-run active", req, 1'b1);
    chk("R8 stop-run flag", status, 8'h80);
    // R1 power down
    c_off = 1; step(1); chk("R1 off req", req, 1'b0);
    chk("R1 off status", status, 8'h00);
    stop = 0; c_off = 0; cmp_low = 0; step(4);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0) begin
        case ($urandom % 3)
          0: begin cmp_low = 0; cmp_ok = 0; end
          1: begin cmp_low = 1; cmp_ok = 0; end
          default: begin cmp_low = 0; cmp_ok = 1; end
        endcase
      end
      if ($urandom % 40 == 0) c_off   = ($urandom % 4 == 0);
      if ($urandom % 30 == 0) c_norst = ($urandom % 3 == 0);
      if ($urandom % 25 == 0) stop    = $urandom % 2;
      if ($urandom % 25 == 0) c_srun  = $urandom % 2;
      if ($urandom % 20 == 0) c_range = $urandom % 2;
      step(1);
      check_all();
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule